// File: doc/BRIEF.md
# Slot-Table Memory Arbiter

This block shares one memory port among fourteen requesting clients. Time is split into a ring of 64 slots, and each slot names one client as its owner. A slot pointer visits one slot per clock. When the owner of the visited slot is requesting, it receives the grant. When the owner is idle, the slot is not wasted: the lowest-numbered client that is requesting takes it instead. A client that owns no slot at all is therefore still served whenever the owners leave slots unused. Two copies of the block serve two memory regions, an external DRAM region and an on-chip memory region, and each copy has its own table.

Software fills the table one entry at a time through a simple write port that carries a slot number and a client number. The grant is registered and one-hot. Each decision is held in a small state register with three named states. DEC_NONE means no grant was issued. DEC_OWNER means the slot owner was granted. DEC_FALLBACK means the lowest requester took an unclaimed slot. The state is re-evaluated on every clock. Any state goes to DEC_OWNER when the current owner requests. It goes to DEC_FALLBACK when the owner is idle but some other client requests. It goes to DEC_NONE when nobody requests.

Top module: `slot_arbiter`

## Requirements
- R1: After reset the grant vector is all zeros, the slot pointer is at slot 0, and slot i holds client i modulo 14.
- R2: The slot pointer moves forward by exactly one slot on every clock after reset, with or without requests, and wraps from slot 63 to slot 0.
- R3: If the owner of the current slot is requesting, then on the following cycle the grant vector has exactly that owner's bit set (bit k = client k).
- R4: If the owner of the current slot is idle and at least one other client requests, the grant goes on the following cycle to the lowest-numbered requesting client.
- R5: If no client requests, the following cycle carries no grant, and the pointer still advances.
- R6: The grant is registered, has at most one bit set, and only names a client that was requesting in the cycle before.
- R7: A table write with write-enable high stores the client number into the addressed slot. If the write targets the slot being decided at the same clock edge, that decision still uses the old owner, and the new owner applies from the next visit to that slot.
- R8: A table write whose client number is 14 or 15 is ignored, and the slot keeps its previous owner.
- R9: A client that owns no slot in the table is still granted through the fallback whenever the owner of the current slot is idle and it is the lowest-numbered requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 14 | Request vector, bit k from client k |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_slot | input | 6 | Slot number to write |
| tbl_wr_client | input | 4 | Client number to store in the slot |
| grant | output | 14 | Registered one-hot grant, bit k for client k |

## Verification
Two things can happen at the same clock edge: a table write to a slot, and the arbitration decision that reads that same slot. The bench provokes this by writing to the slot under the pointer while every client requests. It expects the old owner to win at that edge and the new owner to win one lap of 64 slots later. Random traffic mixes writes with sparse request patterns, so owner grants and fallback grants fall close to table updates. Some of those writes carry client numbers that are out of range.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
    typedef enum logic [1:0] {
        DEC_NONE     = 2'd0,
        DEC_OWNER    = 2'd1,
        DEC_FALLBACK = 2'd2
    } dec_kind_e;
endpackage

// File: rtl/slot_arb_table.sv
module slot_arb_table #(
    parameter int N_CLIENTS = 14,
    parameter int N_SLOTS   = 64,
    localparam int CW = $clog2(N_CLIENTS),
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [CW-1:0] wr_client,
    input  logic [SW-1:0] rd_slot,
    output logic [CW-1:0] rd_client
);
    localparam logic [CW-1:0] LAST_CLIENT = CW'(N_CLIENTS - 1);

    logic [N_SLOTS-1:0][CW-1:0] ent;
    logic                       wr_ok;

    // R8: out-of-range client numbers never reach the table
    assign wr_ok = wr_en && (wr_client <= LAST_CLIENT);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[s] <= CW'(s % N_CLIENTS);
            end else if (wr_ok && (wr_slot == SW'(s))) begin
                ent[s] <= wr_client;
            end
        end
    end

    assign rd_client = ent[rd_slot];

    a_r8_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_client > LAST_CLIENT)) |=> $stable(ent));

    a_r8_owner_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_client <= LAST_CLIENT);

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (ent[$past(wr_slot)] == $past(wr_client)));
endmodule

// File: rtl/slot_arb_ptr.sv
module slot_arb_ptr #(
    parameter int N_SLOTS = 64,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] ptr
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(N_SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr == LAST_SLOT) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

    a_r2_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != LAST_SLOT) |=> (ptr == $past(ptr) + 1'b1));

    a_r2_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == LAST_SLOT) |=> (ptr == '0));
endmodule

// File: rtl/slot_arb_pick.sv
module slot_arb_pick #(
    parameter int N_CLIENTS = 14,
    localparam int CW = $clog2(N_CLIENTS)
) (
    input  logic [N_CLIENTS-1:0] req,
    output logic                 any,
    output logic [CW-1:0]        idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_CLIENTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = CW'(i);
            end
        end
    end

    always_comb begin
        if (any) begin
            a_r4_pick_is_requester: assert (req[idx]);
        end
    end
endmodule

// File: rtl/slot_arb_fsm.sv
module slot_arb_fsm
    import slot_arb_pkg::*;
#(
    parameter int N_CLIENTS = 14,
    localparam int CW = $clog2(N_CLIENTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] req,
    input  logic [CW-1:0]        owner,
    input  logic                 pick_any,
    input  logic [CW-1:0]        pick_idx,
    output logic [N_CLIENTS-1:0] grant
);
    dec_kind_e     dec_q, dec_d;
    logic [CW-1:0] win_q, win_d;

    // next decision
    always_comb begin
        if (req[owner]) begin
            dec_d = DEC_OWNER;
            win_d = owner;
        end else if (pick_any) begin
            dec_d = DEC_FALLBACK;
            win_d = pick_idx;
        end else begin
            dec_d = DEC_NONE;
            win_d = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= DEC_NONE;
            win_q <= '0;
        end else begin
            dec_q <= dec_d;
            win_q <= win_d;
        end
    end

    // outputs
    always_comb begin
        unique case (dec_q)
            DEC_OWNER, DEC_FALLBACK: grant = N_CLIENTS'(1) << win_q;
            default:                 grant = '0;
        endcase
    end

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_granted_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~$past(req)) == '0);

    a_r3_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req[owner] |=> (grant == (N_CLIENTS'(1) << $past(owner))));

    a_r4_lowest_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (!req[owner] && (req != '0)) |=>
            ((grant != '0) && (($past(req) & (grant - 1'b1)) == '0)));

    a_r5_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (grant == '0));
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
    parameter int N_CLIENTS = 14,
    parameter int N_SLOTS   = 64,
    localparam int CW = $clog2(N_CLIENTS),
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] req,
    input  logic                 tbl_wr_en,
    input  logic [SW-1:0]        tbl_wr_slot,
    input  logic [CW-1:0]        tbl_wr_client,
    output logic [N_CLIENTS-1:0] grant
);
    logic [SW-1:0] ptr;
    logic [CW-1:0] owner;
    logic          pick_any;
    logic [CW-1:0] pick_idx;

    slot_arb_ptr #(.N_SLOTS(N_SLOTS)) u_ptr (
        .clk (clk),
        .rst_n (rst_n),
        .ptr (ptr)
    );

    slot_arb_table #(.N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr_en),
        .wr_slot   (tbl_wr_slot),
        .wr_client (tbl_wr_client),
        .rd_slot   (ptr),
        .rd_client (owner)
    );

    slot_arb_pick #(.N_CLIENTS(N_CLIENTS)) u_pick (
        .req (req),
        .any (pick_any),
        .idx (pick_idx)
    );

    slot_arb_fsm #(.N_CLIENTS(N_CLIENTS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .owner    (owner),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .grant    (grant)
    );
endmodule

// File: tb/sim_slot_arbiter.sv
module sim_slot_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 14;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_slot = '0;
    logic [3:0]    wr_client = '0;
    logic [NC-1:0] grant;

    int n_cmp = 0;
    int n_bad = 0;
    int m_tbl [NS];
    int m_ptr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_arbiter u0 (
        .clk (clk), .rst_n (rst_n), .req (req),
        .tbl_wr_en (wr_en), .tbl_wr_slot (wr_slot), .tbl_wr_client (wr_client),
        .grant (grant)
    );

    function automatic logic [NC-1:0] exp_grant(input logic [NC-1:0] r, input int own);
        if (r[own]) return NC'(1) << own;
        for (int i = 0; i < NC; i++) if (r[i]) return NC'(1) << i;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [NC-1:0] exp);
        n_cmp++;
        if (grant !== exp) begin
            n_bad++;
            $display("FAIL %s: grant=%h expected=%h", tag, grant, exp);
        end
    endtask

    // drive one decision at a negedge, check its result at the next negedge
    task automatic step(input string tag, input logic [NC-1:0] r,
                        input bit we, input int s, input int c);
        logic [NC-1:0] e;
        req = r; wr_en = we; wr_slot = 6'(s); wr_client = 4'(c);
        e = exp_grant(r, m_tbl[m_ptr]);
        if (we && c < NC) m_tbl[s] = c;
        m_ptr = (m_ptr + 1) % NS;
        @(negedge clk);
        check(tag, e);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: cycles=100000 expected=finish");
        summary();
    end

    initial begin
        int seed;
        logic [NC-1:0] r;
        int p;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < NS; i++) m_tbl[i] = i % NC;
        repeat (3) @(negedge clk);
        check("R1 reset grant", '0);
        rst_n = 1'b1;
        // R1 R2 R3: all request, reset table pattern and wrap
        for (int i = 0; i < 70; i++) step("R1 R2 R3 reset table", '1, 0, 0, 0);
        // R5 idle
        for (int i = 0; i < 5; i++) step("R5 idle", '0, 0, 0, 0);
        // R7 fill all slots with client 0, no requests
        for (int i = 0; i < NS; i++) step("R5 R7 fill", '0, 1, i, 0);
        // R4 owner 0 idle, lowest of 3 and 9
        for (int i = 0; i < 4; i++) step("R4 fallback lowest", 14'h0208, 0, 0, 0);
        // R9 client 13 owns nothing
        for (int i = 0; i < 4; i++) step("R9 unowned client", 14'h2000, 0, 0, 0);
        // R7 same-edge write to the slot under decision
        p = m_ptr;
        step("R7 same edge old owner", '1, 1, p, 7);
        for (int i = 0; i < NS; i++) step("R7 new owner next lap", '1, 0, 0, 0);
        // R8 out-of-range writes ignored
        p = (m_ptr + 1) % NS;
        step("R8 bad write 14", '1, 1, p, 14);
        step("R8 bad write 15", '1, 1, (p + 1) % NS, 15);
        for (int i = 0; i < NS; i++) step("R8 slots unchanged", '1, 0, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            r = NC'($urandom) & NC'($urandom) & NC'($urandom);
            if ($urandom % 8 == 0) r = '0;
            if ($urandom % 4 == 0)
                step("R3 R4 R7 R8 random", r, 1, int'($urandom % NS), int'($urandom % 16));
            else
                step("R3 R4 R6 random", r, 0, 0, 0);
            n_cmp++;
            if ($countones(grant) > 1) begin
                n_bad++;
                $display("FAIL R6 onehot: grant=%h expected=at most one bit", grant);
            end
        end
        summary();
    end
endmodule